// File: doc/BRIEF.md
# Perpendicular Recording Mode Controller

This block holds the perpendicular-recording setting of a floppy disk controller and turns it into the write format of the current access. A command parameter byte loads a global mode pair (gap select and early-gate select), four per-drive automatic-perpendicular bits and an overwrite-enable bit that guards those per-drive bits. Separate soft-reset and hard-reset strobes clear the setting to different depths.

For the drive that is selected now, the block reports whether the drive is treated as perpendicular, the Gap2 field length, how many Gap2 bytes the write itself lays down, and whether write precompensation is forced to zero. These outputs are combinational from the stored setting, the drive select and the data-rate code, so a change of drive applies at once with no new command. A small byte counter, started at the head of Gap2, raises the write gate once the untouched part of Gap2 has passed and holds it until the write ends.

Top module: `perp_mode_ctl`

## Requirements
- R1: After the asynchronous reset `rstN` is low, every drive is conventional: `perpActive`=0, `gap2Len`=22, `gap2Wr`=0, `precompZero`=0, and `precompOut` equals `precompIn`.
- R2: A command (`cmdValid`=1) loads the global gap bit from `cmdByte[0]` and the early-gate bit from `cmdByte[1]`; the pair {gate,gap} decodes as 00 conventional (22/0), 01 perpendicular half rate (22/19, `perpActive`=1), 10 reserved and conventional (22/0), 11 perpendicular full rate (41/38, `perpActive`=1).
- R3: With the global pair at 00, a drive whose per-drive bit (`cmdByte[2]` for drive 0 up to `cmdByte[5]` for drive 3) is 1 is perpendicular: 41/38 when `rateSel` is 3 (1 Mbps), 22/19 for any other rate code.
- R4: When either global bit is 1, the per-drive bits have no effect on any output.
- R5: The per-drive bits load from a command only when `cmdByte[7]` (overwrite enable) is 1; otherwise they keep their value while the global pair still loads.
- R6: `precompZero` is 1 exactly when the selected drive is perpendicular through its per-drive bit; then `precompOut` is 0, otherwise `precompOut` equals `precompIn`.
- R7: `softRst` clears both global bits and leaves the per-drive bits unchanged.
- R8: `hardRst` clears both global bits and all per-drive bits.
- R9: `writeStart` latches the threshold `gap2Len - gap2Wr` (3 in both perpendicular formats, 22 in conventional) and clears `wgateOut`; `wgateOut` rises in the cycle after the threshold-th `byteStrobe` and stays 1 through further strobes until `writeEnd` clears it.
- R10: The format outputs follow `driveSel` and `rateSel` in the same cycle, with no clock edge needed.
- R11: In one cycle `hardRst` wins over `softRst`, and either reset wins over a command, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous chip reset, active low, clears all setting |
| cmdValid | input | 1 | Command parameter byte valid for one cycle |
| cmdByte | input | 8 | Parameter byte: [0] gap, [1] early gate, [5:2] per-drive bits, [7] overwrite enable |
| softRst | input | 1 | Soft-reset strobe |
| hardRst | input | 1 | Hard-reset strobe |
| driveSel | input | 2 | Selected drive number |
| rateSel | input | 2 | Programmed data-rate code, 3 means 1 Mbps |
| precompIn | input | 3 | Programmed precompensation value |
| writeStart | input | 1 | Start of Gap2 for a write access |
| byteStrobe | input | 1 | One pulse per byte time |
| writeEnd | input | 1 | End of the write (after CRC) |
| perpActive | output | 1 | Selected drive treated as perpendicular |
| gap2Len | output | 6 | Gap2 field length in bytes |
| gap2Wr | output | 6 | Gap2 bytes written by the write operation |
| precompZero | output | 1 | Precompensation forced to zero |
| precompOut | output | 3 | Precompensation value to apply |
| wgateOut | output | 1 | Write gate |

## Verification
Random command bytes with and without the overwrite bit are mixed with soft and hard resets, some landing in the same cycle, and after each step all four drives are read under random rate codes; this separates the global decode from the per-drive path, and shows whether per-drive bits leak through when the global pair is non-zero. Directed cases then set alternating per-drive bits and sweep the drive select without a clock, which tells combinational selection from a latched one, and run the gate counter in both perpendicular formats and in conventional mode, telling a 3-byte early gate from a 22-byte one and checking that the gate holds until the end strobe.

// File: rtl/perp_mode_pkg.sv
package perp_mode_pkg;
  localparam int CMD_W   = 8;
  localparam int BIT_GAP = 0;
  localparam int BIT_WG  = 1;
  localparam int BIT_DRV = 2;
  localparam int BIT_OW  = 7;

  typedef struct packed {
    logic loadGlobal;
    logic loadDrives;
    logic clrGlobal;
    logic clrDrives;
  } pm_strb_t;
endpackage

// File: rtl/perp_mode_ctrl.sv
module perp_mode_ctrl
  import perp_mode_pkg::*;
(
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             softRst,
  input  logic             hardRst,
  output pm_strb_t         strb
);
  // R11: hard reset > soft reset > command
  always_comb begin
    strb.clrDrives  = hardRst;
    strb.clrGlobal  = hardRst | softRst;
    strb.loadGlobal = cmdValid & ~hardRst & ~softRst;
    strb.loadDrives = strb.loadGlobal & cmdByte[BIT_OW];
  end
endmodule

// File: rtl/perp_mode_dp.sv
module perp_mode_dp
  import perp_mode_pkg::*;
#(
  parameter int NUM_DRV  = 4,
  parameter int LEN_W    = 6,
  parameter int PC_W     = 3,
  parameter int RATE_W   = 2,
  parameter int RATE_1M  = 3,
  parameter int LEN_STD  = 22,
  parameter int LEN_FAST = 41,
  parameter int WR_HALF  = 19,
  parameter int WR_FAST  = 38,
  localparam int DRV_W   = $clog2(NUM_DRV)
)(
  input  logic              clk,
  input  logic              rstN,
  input  pm_strb_t          strb,
  input  logic [CMD_W-1:0]  cmdByte,
  input  logic [DRV_W-1:0]  driveSel,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [PC_W-1:0]   precompIn,
  output logic              perpActive,
  output logic [LEN_W-1:0]  gap2Len,
  output logic [LEN_W-1:0]  gap2Wr,
  output logic              precompZero,
  output logic [PC_W-1:0]   precompOut
);
  logic               glbGap, glbWg;
  logic [NUM_DRV-1:0] drvBits;
  logic               autoPerp, fastFmt, halfFmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glbGap  <= 1'b0;
      glbWg   <= 1'b0;
      drvBits <= '0;
    end else begin
      if (strb.clrGlobal) begin
        glbGap <= 1'b0;
        glbWg  <= 1'b0;
      end else if (strb.loadGlobal) begin
        glbGap <= cmdByte[BIT_GAP];
        glbWg  <= cmdByte[BIT_WG];
      end
      if (strb.clrDrives) drvBits <= '0;
      else if (strb.loadDrives) drvBits <= cmdByte[BIT_DRV +: NUM_DRV];
    end
  end

  always_comb begin
    autoPerp = !glbGap && !glbWg && drvBits[driveSel];
    fastFmt  = (glbGap && glbWg) || (autoPerp && rateSel == RATE_W'(RATE_1M));
    halfFmt  = (glbGap && !glbWg) || (autoPerp && rateSel != RATE_W'(RATE_1M));
    perpActive  = fastFmt || halfFmt;
    gap2Len     = fastFmt ? LEN_W'(LEN_FAST) : LEN_W'(LEN_STD);
    gap2Wr      = fastFmt ? LEN_W'(WR_FAST) : (halfFmt ? LEN_W'(WR_HALF) : '0);
    precompZero = autoPerp;
    precompOut  = autoPerp ? '0 : precompIn;
  end

  a_r5_ow_guard: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadGlobal && !strb.loadDrives && !strb.clrDrives) |=> $stable(drvBits));
  a_r7_soft_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrGlobal && !strb.clrDrives) |=> ($stable(drvBits) && !glbGap && !glbWg));
  a_r8_hard_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrDrives |=> (drvBits == '0 && !glbGap && !glbWg));
  a_r4_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (glbGap || glbWg) |-> !precompZero);
  a_r2_len_pair: assert property (@(posedge clk) disable iff (!rstN)
    !perpActive |-> (gap2Wr == '0 && gap2Len == LEN_W'(LEN_STD)));
endmodule

// File: rtl/perp_gate_cnt.sv
module perp_gate_cnt #(
  parameter int LEN_W = 6
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] gap2Len,
  input  logic [LEN_W-1:0] gap2Wr,
  input  logic             writeStart,
  input  logic             byteStrobe,
  input  logic             writeEnd,
  output logic             wgateOut
);
  logic             active;
  logic [LEN_W-1:0] cnt, thr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
      thr    <= '0;
    end else if (writeStart) begin
      active <= 1'b1;
      cnt    <= '0;
      thr    <= gap2Len - gap2Wr;
    end else if (writeEnd) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active && byteStrobe && cnt != thr) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign wgateOut = active && (cnt == thr);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wgateOut && !writeStart && !writeEnd) |=> wgateOut);
  a_r9_end_drop: assert property (@(posedge clk) disable iff (!rstN)
    (writeEnd && !writeStart) |=> !wgateOut);
  a_r9_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (writeStart && gap2Len != gap2Wr) |=> !wgateOut);
endmodule

// File: rtl/perp_mode_ctl.sv
module perp_mode_ctl
  import perp_mode_pkg::*;
#(
  parameter int NUM_DRV = 4,
  parameter int LEN_W   = 6,
  parameter int PC_W    = 3,
  parameter int RATE_W  = 2,
  localparam int DRV_W  = $clog2(NUM_DRV)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdByte,
  input  logic              softRst,
  input  logic              hardRst,
  input  logic [DRV_W-1:0]  driveSel,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [PC_W-1:0]   precompIn,
  input  logic              writeStart,
  input  logic              byteStrobe,
  input  logic              writeEnd,
  output logic              perpActive,
  output logic [LEN_W-1:0]  gap2Len,
  output logic [LEN_W-1:0]  gap2Wr,
  output logic              precompZero,
  output logic [PC_W-1:0]   precompOut,
  output logic              wgateOut
);
  pm_strb_t strb;

  perp_mode_ctrl i_ctrl (
    .cmdValid(cmdValid), .cmdByte(cmdByte),
    .softRst(softRst), .hardRst(hardRst), .strb(strb)
  );

  perp_mode_dp #(.NUM_DRV(NUM_DRV), .LEN_W(LEN_W), .PC_W(PC_W), .RATE_W(RATE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdByte(cmdByte),
    .driveSel(driveSel), .rateSel(rateSel), .precompIn(precompIn),
    .perpActive(perpActive), .gap2Len(gap2Len), .gap2Wr(gap2Wr),
    .precompZero(precompZero), .precompOut(precompOut)
  );

  perp_gate_cnt #(.LEN_W(LEN_W)) i_gate (
    .clk(clk), .rstN(rstN), .gap2Len(gap2Len), .gap2Wr(gap2Wr),
    .writeStart(writeStart), .byteStrobe(byteStrobe), .writeEnd(writeEnd),
    .wgateOut(wgateOut)
  );
endmodule

// File: tb/test_perp_mode_ctl.sv
`timescale 1ns/1ps
module test_perp_mode_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0, softRst = 1'b0, hardRst = 1'b0;
  logic [7:0] cmdByte = '0;
  logic [1:0] driveSel = '0, rateSel = '0;
  logic [2:0] precompIn = 3'd5;
  logic       writeStart = 1'b0, byteStrobe = 1'b0, writeEnd = 1'b0;
  logic       perpActive, precompZero, wgateOut;
  logic [5:0] gap2Len, gap2Wr;
  logic [2:0] precompOut;

  int nChecks = 0, nFails = 0;
  logic       mGap = 1'b0, mWg = 1'b0;
  logic [3:0] mDrv = '0;

  always #2.5 clk = ~clk;

  perp_mode_ctl i_perp_mode_ctl (.*);

  // expected {perp, len, wr, pz}
  function automatic logic [13:0] expFmt(logic g, logic w, logic [3:0] d, logic [1:0] drv, logic [1:0] rate);
    logic autoP;
    autoP = !g && !w && d[drv];
    if (g && w)            return {1'b1, 6'd41, 6'd38, 1'b0};
    if (g && !w)           return {1'b1, 6'd22, 6'd19, 1'b0};
    if (autoP && rate == 3) return {1'b1, 6'd41, 6'd38, 1'b1};
    if (autoP)             return {1'b1, 6'd22, 6'd19, 1'b1};
    return {1'b0, 6'd22, 6'd0, 1'b0};
  endfunction

  task automatic checkFmt(string tag);
    logic [13:0] e;
    logic [2:0]  ePc;
    e   = expFmt(mGap, mWg, mDrv, driveSel, rateSel);
    ePc = e[0] ? 3'd0 : precompIn;
    nChecks++;
    if ({perpActive, gap2Len, gap2Wr, precompZero} !== e || precompOut !== ePc) begin
      nFails++;
      $display("FAIL %s: drv=%0d rate=%0d got perp=%0d len=%0d wr=%0d pz=%0d pc=%0d exp perp=%0d len=%0d wr=%0d pz=%0d pc=%0d",
               tag, driveSel, rateSel, perpActive, gap2Len, gap2Wr, precompZero, precompOut,
               e[13], e[12:7], e[6:1], e[0], ePc);
    end
  endtask

  task automatic checkGate(logic exp, string tag);
    nChecks++;
    if (wgateOut !== exp) begin
      nFails++;
      $display("FAIL %s: wgateOut got %0d exp %0d", tag, wgateOut, exp);
    end
  endtask

  // one cycle of stimulus, model updated per R5 R7 R8 R11
  task automatic step(logic cv, logic [7:0] b, logic sr, logic hr);
    @(negedge clk);
    cmdValid = cv; cmdByte = b; softRst = sr; hardRst = hr;
    @(negedge clk);
    cmdValid = 0; softRst = 0; hardRst = 0;
    if (hr) begin mGap = 0; mWg = 0; mDrv = '0; end
    else if (sr) begin mGap = 0; mWg = 0; end
    else if (cv) begin
      mGap = b[0]; mWg = b[1];
      if (b[7]) mDrv = b[5:2];
    end
  endtask

  task automatic sweepDrives(string tag);
    for (int k = 0; k < 4; k++) begin
      driveSel = 2'(k);
      rateSel  = 2'($urandom_range(0, 3));
      #0.5;
      checkFmt(tag);
    end
  endtask

  task automatic runGate(int thr, string tag);
    @(negedge clk); writeStart = 1;
    @(negedge clk); writeStart = 0;
    for (int i = 0; i <= thr; i++) begin
      checkGate(i >= thr, tag);
      byteStrobe = 1;
      @(negedge clk); byteStrobe = 0;
      @(negedge clk);
    end
    checkGate(1'b1, tag);          // still held after extra strobe
    writeEnd = 1;
    @(negedge clk); writeEnd = 0;
    checkGate(1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    sweepDrives("R1 reset state");
    rstN = 1;
    @(negedge clk);
    checkGate(1'b0, "R1 gate idle");

    // R2 global decode, all four codes
    for (int c = 0; c < 4; c++) begin
      step(1, 8'(c), 0, 0);
      sweepDrives("R2 global decode");
    end
    // R3 per-drive bits, alternating, sweep rates
    step(1, 8'b1001_0100, 0, 0);            // OW, drives 0 and 2
    for (int r = 0; r < 4; r++) begin
      rateSel = 2'(r);
      for (int k = 0; k < 4; k++) begin
        driveSel = 2'(k); #0.5; checkFmt("R3 R6 R10 per-drive sweep");
      end
    end
    // R4 global bit set hides per-drive bits
    step(1, 8'b0001_0101, 0, 0);            // gap=1, no OW
    sweepDrives("R4 per-drive ignored");
    // R5 no OW keeps drive bits
    step(1, 8'b0011_1100, 0, 0);
    sweepDrives("R5 no overwrite");
    // R7 soft reset keeps drive bits
    step(1, 8'b0000_0011, 0, 0);
    step(0, 8'h00, 1, 0);
    sweepDrives("R7 soft reset");
    // R11 same-cycle priority
    step(1, 8'b1011_1111, 1, 0);
    sweepDrives("R11 soft beats command");
    step(1, 8'b1011_1111, 1, 1);
    sweepDrives("R11 hard beats all");
    // R8 hard reset
    step(1, 8'b1011_1100, 0, 0);
    step(0, 8'h00, 0, 1);
    sweepDrives("R8 hard reset");

    // R9 gate counter in the three formats
    step(1, 8'b0000_0011, 0, 0);
    runGate(3, "R9 gate fast perp");
    step(1, 8'b0000_0001, 0, 0);
    runGate(3, "R9 gate half perp");
    step(1, 8'b0000_0000, 0, 0);
    driveSel = 0; #0.5;
    runGate(22, "R9 gate conventional");

    // random mix
    for (int n = 0; n < 300; n++) begin
      int kind;
      kind = $urandom_range(0, 9);
      precompIn = 3'($urandom_range(0, 7));
      step(kind < 7, 8'($urandom), kind == 7 || kind == 9, kind == 8);
      sweepDrives("R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule